// File: doc/BRIEF.md
# Half-Duplex SPI Command Engine

This block is a register-mapped SPI master that performs one flash-style command each time software triggers it. Software fills a byte-addressed buffer window with the bytes to send, programs an 8-bit command byte, a send count, a receive count and a target number, then sets the start bit in the control word. The engine drives the selected active-low select line, shifts out the command byte and the send bytes MSB first, then clocks in the requested receive bytes and writes them into the same buffer directly behind the sent data.

Software learns that a command has finished by polling a busy flag, either in the control word or in a status byte. The status byte also has a sticky completion flag that clears when it is read. Send and receive phases never overlap, so the line from the target is ignored while data goes out. A buffer-rewind control returns the shared buffer position to index 0. Without it, the next command continues at the index after the last byte of the previous one.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every select line is high, the serial clock is low, and both the control word (0x00) and the status byte (0x4C) read as zero.
- R2: Register map, all read back through `bus_rdata` one cycle after `bus_rd`. 0x00 holds the command byte in bits 7:0 and reads busy in bit 31. 0x1D holds the target number in bits 1:0. 0x48 holds the send count and 0x4B the receive count, 8 bits each. Buffer index k is read and written at 0x80+k for k from 0 to 71.
- R3: A command places exactly 8*(1+S+R) rising clock edges on the bus. S and R are the effective send and receive counts. The bits form the command byte, then the buffer bytes at positions P..P+S-1 (P is the buffer position), each byte MSB first.
- R4: Receive byte j is written into the buffer at position P+S+j, so after a rewind software reads it at 0x80+S+j.
- R5: During the receive phase the output data line is held low. Nothing is captured during the send phase, so buffer bytes at P..P+S-1 are unchanged by the command.
- R6: Only the select line whose number is in 0x1D goes low during a command (active low, lines numbered from bit 0 of `spi_cs_n`).
- R7: Bus mode 0: the clock idles low and data is stable across each rising edge. The clock period is CLK_DIV system cycles. The select line goes low CLK_DIV cycles before the first rising edge and returns high CLK_DIV cycles after the last rising edge.
- R8: Busy (status bit 0 and control bit 31) reads 1 right after the start write and stays 1 until the select line has returned high. The status done flag (bit 1) is set at that point and is cleared by reading 0x4C.
- R9: A start write (control bit 16) issued while busy is ignored: the running command completes unchanged and no second command begins.
- R10: The effective send count is min(tx,72) and the effective receive count is min(rx, 72 - send count), so a command never addresses more than 72 buffer bytes.
- R11: Writing control bit 20 while idle rewinds the buffer position P to 0. Otherwise each command advances P by S+R, modulo 72.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of register access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 32 | Write data (byte registers use bits 7:0) |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | 4 | Active-low select lines, one per target |

## Verification
A wrong byte counter or buffer position shows up as soon as a command ends: the rising-edge count on the bus is off, or received bytes land at the wrong buffer address, or send bytes are overwritten. A wrong divider or phase state shows up on the first bit as a broken lead time or clock period. A stuck done flag or busy flag is caught by the first status read after completion. Random commands with random counts and targets run between directed cases for the empty command, both clamp cases, a start issued while busy, and commands without a rewind whose buffer positions wrap past the end.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and helpers for the SPI command engine.
// Assumes a byte address space of 256 and a buffer of at most 128 bytes.
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL
    } seq_state_t;

    localparam logic [7:0] ADR_CTRL = 8'h00;
    localparam logic [7:0] ADR_CSEL = 8'h1D;
    localparam logic [7:0] ADR_TXC  = 8'h48;
    localparam logic [7:0] ADR_RXC  = 8'h4B;
    localparam logic [7:0] ADR_STAT = 8'h4C;
    localparam logic [7:0] ADR_BUF  = 8'h80;

    localparam int BIT_START = 16;
    localparam int BIT_REWIND = 20;

    // Reduce an index sum below d (sum is known to be below 3*d).
    function automatic int wrap_idx(input int s, input int d);
        int r;
        r = s;
        if (r >= 2 * d) r = r - 2 * d;
        else if (r >= d) r = r - d;
        return r;
    endfunction

endpackage

// File: rtl/spi_cmd_clkdiv.sv
// Half-period tick generator for the serial clock.
// Counts system cycles while run is high; tick pulses every HALF cycles.
// Assumes HALF >= 1. Counter restarts whenever run is low.
module spi_cmd_clkdiv #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Free-running half-period counter, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_cmd_buf.sv
// Shared byte buffer: one write port for the sequencer (priority), one for
// the register bus, and two combinational read ports. Storage is not reset.
// Assumes indices on write ports are below DEPTH.
module spi_cmd_buf #(
    parameter int DEPTH = 72,
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seq_we,
    input  logic [PW-1:0] seq_widx,
    input  logic [7:0]    seq_wdata,
    input  logic          bus_we,
    input  logic [PW-1:0] bus_widx,
    input  logic [7:0]    bus_wdata,
    input  logic [PW-1:0] seq_ridx,
    output logic [7:0]    seq_rdata,
    input  logic [PW-1:0] bus_ridx,
    output logic [7:0]    bus_rdata
);
    logic [7:0] mem [DEPTH];

    assign seq_rdata = (int'(seq_ridx) < DEPTH) ? mem[seq_ridx] : 8'h00;
    assign bus_rdata = (int'(bus_ridx) < DEPTH) ? mem[bus_ridx] : 8'h00;

    // Byte writes; the sequencer wins a same-index collision.
    always_ff @(posedge clk) begin
        if (seq_we) mem[seq_widx] <= seq_wdata;
        if (bus_we && !(seq_we && seq_widx == bus_widx)) mem[bus_widx] <= bus_wdata;
    end

    // R10
    seq_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we |-> (int'(seq_widx) < DEPTH));
endmodule

// File: rtl/spi_cmd_seq.sv
// Command sequencer: lead period, command byte, send bytes, receive bytes,
// trail period. Mode 0, MSB first. Receive bytes go to the buffer behind
// the send bytes. Assumes counts are clamped here against DEPTH.
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH = 72,
    parameter int CS_SEL_W = 2,
    parameter int PW = 7,
    parameter int IW = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     rewind,
    input  logic [7:0]               opcode,
    input  logic [7:0]               tx_cnt,
    input  logic [7:0]               rx_cnt,
    input  logic [CS_SEL_W-1:0]      cs_sel,
    input  logic                     tick,
    input  logic                     miso,
    input  logic [7:0]               buf_rdata,
    output logic [PW-1:0]            buf_ridx,
    output logic                     buf_we,
    output logic [PW-1:0]            buf_widx,
    output logic [7:0]               buf_wdata,
    output logic                     busy,
    output logic                     done_evt,
    output logic                     sclk,
    output logic                     mosi,
    output logic [(1<<CS_SEL_W)-1:0] cs_n
);
    localparam int CS_NUM = 1 << CS_SEL_W;

    seq_state_t          state;
    logic [IW-1:0]       byte_i, tx_n, last_b;
    logic [2:0]          bit_i;
    logic [7:0]          sh, rx_acc;
    logic [PW-1:0]       pos;
    logic [CS_SEL_W-1:0] sel;
    int                  tx_eff, rx_eff;
    logic                rx_phase, rise, fall;

    // Clamp the programmed counts to the buffer size.
    always_comb begin
        tx_eff = (int'(tx_cnt) > DEPTH) ? DEPTH : int'(tx_cnt);
        rx_eff = (int'(rx_cnt) > DEPTH - tx_eff) ? DEPTH - tx_eff : int'(rx_cnt);
    end

    assign rx_phase  = (byte_i > tx_n);
    assign rise      = (state == ST_XFER) && tick && !sclk;
    assign fall      = (state == ST_XFER) && tick && sclk;
    assign buf_ridx  = PW'(wrap_idx(int'(pos) + int'(byte_i), DEPTH));
    assign buf_widx  = PW'(wrap_idx(int'(pos) + int'(byte_i) + DEPTH - 1, DEPTH));
    assign buf_we    = rise && rx_phase && (bit_i == 3'd7);
    assign buf_wdata = {rx_acc[6:0], miso};
    assign busy      = (state != ST_IDLE);
    assign done_evt  = (state == ST_TRAIL) && tick;
    assign mosi      = busy && !rx_phase && sh[3'd7 - bit_i];

    // One select line per target, low only during a command.
    for (genvar g = 0; g < CS_NUM; g++) begin : g_cs
        assign cs_n[g] = !(busy && (int'(sel) == g));
    end

    // Phase sequencing, bit shifting and buffer position tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sclk   <= 1'b0;
            byte_i <= '0;
            bit_i  <= '0;
            tx_n   <= '0;
            last_b <= '0;
            sh     <= '0;
            rx_acc <= '0;
            pos    <= '0;
            sel    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state  <= ST_LEAD;
                        sh     <= opcode;
                        byte_i <= '0;
                        bit_i  <= '0;
                        tx_n   <= IW'(tx_eff);
                        last_b <= IW'(tx_eff + rx_eff);
                        sel    <= cs_sel;
                    end
                    if (rewind) pos <= '0;
                end
                ST_LEAD: if (tick) state <= ST_XFER;
                ST_XFER: begin
                    if (rise) begin
                        sclk <= 1'b1;
                        if (rx_phase) rx_acc <= {rx_acc[6:0], miso};
                    end else if (fall) begin
                        sclk <= 1'b0;
                        if (bit_i == 3'd7) begin
                            bit_i <= '0;
                            sh    <= buf_rdata;
                            if (byte_i == last_b) state <= ST_TRAIL;
                            else byte_i <= byte_i + 1'b1;
                        end else begin
                            bit_i <= bit_i + 1'b1;
                        end
                    end
                end
                ST_TRAIL: if (tick) begin
                    state <= ST_IDLE;
                    pos   <= PW'(wrap_idx(int'(pos) + int'(last_b), DEPTH));
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
    // R7
    sclk_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> $past(tick));
    // R6
    clk_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !(&cs_n));
    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> ($stable(sel) && $stable(tx_n) && $stable(last_b)));
endmodule

// File: rtl/spi_cmd_engine.sv
// Top of the SPI command engine: register decode, read mux, sticky done
// flag, and instances of divider, buffer and sequencer.
// Assumes CLK_DIV is even and >= 2, and FIFO_DEPTH <= 128.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int FIFO_DEPTH = 72,
    parameter int CS_SEL_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [7:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     spi_sclk,
    output logic                     spi_mosi,
    input  logic                     spi_miso,
    output logic [(1<<CS_SEL_W)-1:0] spi_cs_n
);
    localparam int HALF = CLK_DIV / 2;
    localparam int PW = $clog2(FIFO_DEPTH);
    localparam int IW = $clog2(FIFO_DEPTH + 1);

    logic [7:0]          opcode, tx_cnt, rx_cnt;
    logic [CS_SEL_W-1:0] cs_sel;
    logic                done_flag, busy, done_evt, tick;
    logic                wr_ctrl, start, rewind, in_win;
    logic [PW-1:0]       win_idx, seq_ridx, seq_widx;
    logic [7:0]          seq_rbyte, seq_wbyte, bus_rbyte;
    logic                seq_we;
    logic [31:0]         rd_mux;

    assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    assign start   = wr_ctrl && bus_wdata[BIT_START];
    assign rewind  = wr_ctrl && bus_wdata[BIT_REWIND] && !busy;
    assign in_win  = (int'(bus_addr) >= int'(ADR_BUF)) &&
                     (int'(bus_addr) < int'(ADR_BUF) + FIFO_DEPTH);
    assign win_idx = PW'(int'(bus_addr) - int'(ADR_BUF));

    // Read data selection by address.
    always_comb begin
        rd_mux = '0;
        if (in_win) rd_mux = {24'h0, bus_rbyte};
        else begin
            case (bus_addr)
                ADR_CTRL: rd_mux = {busy, 23'h0, opcode};
                ADR_CSEL: rd_mux = {{(32-CS_SEL_W){1'b0}}, cs_sel};
                ADR_TXC:  rd_mux = {24'h0, tx_cnt};
                ADR_RXC:  rd_mux = {24'h0, rx_cnt};
                ADR_STAT: rd_mux = {30'h0, done_flag, busy};
                default:  rd_mux = '0;
            endcase
        end
    end

    // Register writes, sticky done flag and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode    <= '0;
            cs_sel    <= '0;
            tx_cnt    <= '0;
            rx_cnt    <= '0;
            done_flag <= 1'b0;
            bus_rdata <= '0;
        end else begin
            if (wr_ctrl) opcode <= bus_wdata[7:0];
            if (bus_wr && bus_addr == ADR_CSEL) cs_sel <= bus_wdata[CS_SEL_W-1:0];
            if (bus_wr && bus_addr == ADR_TXC)  tx_cnt <= bus_wdata[7:0];
            if (bus_wr && bus_addr == ADR_RXC)  rx_cnt <= bus_wdata[7:0];
            if (done_evt) done_flag <= 1'b1;
            else if (bus_rd && bus_addr == ADR_STAT) done_flag <= 1'b0;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

    spi_cmd_clkdiv #(.HALF(HALF)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    spi_cmd_buf #(.DEPTH(FIFO_DEPTH), .PW(PW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .seq_we   (seq_we),
        .seq_widx (seq_widx),
        .seq_wdata(seq_wbyte),
        .bus_we   (bus_wr && in_win),
        .bus_widx (win_idx),
        .bus_wdata(bus_wdata[7:0]),
        .seq_ridx (seq_ridx),
        .seq_rdata(seq_rbyte),
        .bus_ridx (win_idx),
        .bus_rdata(bus_rbyte)
    );

    spi_cmd_seq #(.DEPTH(FIFO_DEPTH), .CS_SEL_W(CS_SEL_W), .PW(PW), .IW(IW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rewind   (rewind),
        .opcode   (bus_wdata[7:0]),
        .tx_cnt   (tx_cnt),
        .rx_cnt   (rx_cnt),
        .cs_sel   (cs_sel),
        .tick     (tick),
        .miso     (spi_miso),
        .buf_rdata(seq_rbyte),
        .buf_ridx (seq_ridx),
        .buf_we   (seq_we),
        .buf_widx (seq_widx),
        .buf_wdata(seq_wbyte),
        .busy     (busy),
        .done_evt (done_evt),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n)
    );

    // R8
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);
    // R7
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !spi_sclk);
endmodule

// File: tb/spi_cmd_engine_tb.sv
// Self-checking bench: random and directed commands against a bench model
// of the buffer and a behavioural SPI target.
module spi_cmd_engine_tb;
    localparam int DIV = 4;
    localparam int DEPTH = 72;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [3:0]  spi_cs_n;

    int vectors = 0, miscompares = 0;
    bit finished = 0;

    logic [7:0] fifo_m [DEPTH];
    logic [7:0] slv_rx [80];
    logic [7:0] cap [80];
    int ptr_m = 0, exp_tx_g = 0;
    int cyc = 0, rise_cnt = 0, cs_fall_cyc = 0, cs_rise_cyc = 0;
    int first_rise = 0, last_rise = 0, period_err = 0, cs_falls = 0;
    logic [3:0] cs_seen = '0;
    logic sclk_q = 1'b0, sel_q = 1'b0;

    spi_cmd_engine #(.CLK_DIV(DIV), .FIFO_DEPTH(DEPTH), .CS_SEL_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    always #10 clk = ~clk;

    function automatic int wrapm(input int s);
        return s % DEPTH;
    endfunction

    // Target output bit k: filler during the send phase, then receive data.
    function automatic logic slave_bit(input int k);
        int nb;
        nb = 8 * (1 + exp_tx_g);
        if (k < nb) return logic'((k ^ (k >> 2)) & 1);
        return slv_rx[(k - nb) / 8][7 - ((k - nb) % 8)];
    endfunction

    // Bus monitor and target model, sampled mid-cycle.
    always @(negedge clk) begin
        logic sel_now;
        cyc++;
        sel_now = ~&spi_cs_n;
        if (sel_now && !sel_q) begin
            cs_fall_cyc = cyc; rise_cnt = 0; cs_seen = '0; period_err = 0;
            cs_falls++; spi_miso = slave_bit(0);
        end
        if (!sel_now && sel_q) cs_rise_cyc = cyc;
        if (spi_sclk && !sclk_q) begin
            if (rise_cnt == 0) first_rise = cyc;
            else if (cyc - last_rise != DIV) period_err++;
            last_rise = cyc;
            if (rise_cnt < 640) cap[rise_cnt / 8][7 - (rise_cnt % 8)] = spi_mosi;
            cs_seen = cs_seen | ~spi_cs_n;
            rise_cnt++;
        end
        if (!spi_sclk && sclk_q) spi_miso = slave_bit(rise_cnt);
        sclk_q = spi_sclk;
        sel_q = sel_now;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic run_cmd(input logic [7:0] op, input int txc, input int rxc,
                           input int csel, input bit rewind, input bit dbl,
                           input string tag);
        int et, er, falls0, n, bad, badi;
        logic [31:0] st;
        et = (txc > DEPTH) ? DEPTH : txc;
        er = (rxc > DEPTH - et) ? DEPTH - et : rxc;
        if (rewind) begin bus_write(8'h00, 32'h0010_0000); ptr_m = 0; end
        for (int i = 0; i < et; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            fifo_m[wrapm(ptr_m + i)] = v;
            bus_write(8'(8'h80 + wrapm(ptr_m + i)), {24'h0, v});
        end
        for (int i = 0; i < er; i++) slv_rx[i] = 8'($urandom);
        exp_tx_g = et;
        bus_write(8'h48, 32'(txc));
        bus_write(8'h4B, 32'(rxc));
        bus_write(8'h1D, 32'(csel));
        falls0 = cs_falls;
        bus_write(8'h00, 32'h0001_0000 | {24'h0, op});
        bus_read(8'h4C, st);
        chk(st[0] == 1'b1, "R8 busy right after start", int'(st[0]), 1);
        if (dbl) bus_write(8'h00, 32'h0001_0000 | {24'h0, ~op});
        bus_read(8'h00, st);
        chk(st[31] == 1'b1, "R2 control busy bit", int'(st[31]), 1);
        n = 0;
        do begin bus_read(8'h4C, st); n++; end while (st[0] && n < 5000);
        chk(st[1:0] == 2'b10, {"R8 done at end ", tag}, int'(st[1:0]), 2);
        bus_read(8'h4C, st);
        chk(st[1] == 1'b0, "R8 done cleared by read", int'(st[1]), 0);
        chk(rise_cnt == 8 * (1 + et + er), {"R3 edge count ", tag}, rise_cnt, 8 * (1 + et + er));
        chk(cap[0] == op, "R3 command byte", int'(cap[0]), int'(op));
        bad = 0; badi = 0;
        for (int i = 0; i < et; i++)
            if (cap[1 + i] != fifo_m[wrapm(ptr_m + i)]) begin bad++; badi = i; end
        chk(bad == 0, {"R3 send bytes ", tag}, int'(cap[1 + badi]), int'(fifo_m[wrapm(ptr_m + badi)]));
        bad = 0;
        for (int i = 0; i < er; i++) if (cap[1 + et + i] != 8'h00) bad++;
        chk(bad == 0, "R5 output low while receiving", bad, 0);
        chk(cs_seen == 4'(1 << csel), "R6 select line", int'(cs_seen), 1 << csel);
        chk(first_rise - cs_fall_cyc == DIV, "R7 lead time", first_rise - cs_fall_cyc, DIV);
        chk(cs_rise_cyc - last_rise == DIV, "R7 trail time", cs_rise_cyc - last_rise, DIV);
        chk(period_err == 0, "R7 clock period", period_err, 0);
        chk(cs_falls - falls0 == 1, "R9 single command", cs_falls - falls0, 1);
        for (int i = 0; i < et; i++) begin
            bus_read(8'(8'h80 + wrapm(ptr_m + i)), st);
            if (st[7:0] != fifo_m[wrapm(ptr_m + i)])
                chk(1'b0, "R5 send byte overwritten", int'(st[7:0]), int'(fifo_m[wrapm(ptr_m + i)]));
        end
        for (int i = 0; i < er; i++) begin
            bus_read(8'(8'h80 + wrapm(ptr_m + et + i)), st);
            chk(st[7:0] == slv_rx[i], {"R4 received byte ", tag}, int'(st[7:0]), int'(slv_rx[i]));
            fifo_m[wrapm(ptr_m + et + i)] = slv_rx[i];
        end
        ptr_m = wrapm(ptr_m + et + er);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++; vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 4'hF, "R1 selects high", int'(spi_cs_n), 15);
        chk(spi_sclk == 1'b0, "R1 clock low", int'(spi_sclk), 0);
        bus_read(8'h4C, rd);
        chk(rd == 32'h0, "R1 status zero", int'(rd), 0);
        bus_read(8'h00, rd);
        chk(rd == 32'h0, "R1 control zero", int'(rd), 0);
        // R2 register readback
        bus_write(8'h48, 32'hA5); bus_read(8'h48, rd);
        chk(rd == 32'hA5, "R2 send count", int'(rd), 'hA5);
        bus_write(8'h4B, 32'h3C); bus_read(8'h4B, rd);
        chk(rd == 32'h3C, "R2 receive count", int'(rd), 'h3C);
        bus_write(8'h1D, 32'hFE); bus_read(8'h1D, rd);
        chk(rd == 32'h2, "R2 target number", int'(rd), 2);
        bus_write(8'h00, 32'h9F); bus_read(8'h00, rd);
        chk(rd == 32'h9F, "R2 command byte", int'(rd), 'h9F);
        bus_write(8'hC7, 32'h5A); bus_read(8'hC7, rd);
        chk(rd == 32'h5A, "R2 last buffer byte", int'(rd), 'h5A);
        fifo_m[71] = 8'h5A;
        // Directed corner cases
        run_cmd(8'h05, 0, 0, 0, 1'b1, 1'b0, "R3 empty");
        run_cmd(8'h9F, 0, 3, 3, 1'b1, 1'b0, "R4 read only");
        run_cmd(8'h02, 4, 2, 1, 1'b1, 1'b1, "R9 start while busy");
        run_cmd(8'h0B, 70, 10, 2, 1'b1, 1'b0, "R10 receive clamp");
        run_cmd(8'h03, 200, 5, 0, 1'b1, 1'b0, "R10 send clamp");
        // R11 no rewind: continue at the position after the last command
        run_cmd(8'h3B, 2, 1, 1, 1'b1, 1'b0, "R11 base");
        run_cmd(8'h6B, 1, 1, 1, 1'b0, 1'b0, "R11 continue");
        run_cmd(8'hEB, 60, 5, 3, 1'b0, 1'b0, "R11 advance");
        run_cmd(8'hBB, 5, 4, 2, 1'b0, 1'b0, "R11 wrap");
        // Random commands with rewind
        for (int k = 0; k < 10; k++)
            run_cmd(8'($urandom), int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
                    int'($urandom_range(0, 3)), 1'b1, 1'b0, "random");
        // R9 no late command after an ignored start
        repeat (50) @(negedge clk);
        chk(spi_cs_n == 4'hF, "R9 idle after commands", int'(spi_cs_n), 15);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule